// File: doc/BRIEF.md
# Steered Serial Programming Interface

This block loads the divider settings of two frequency-synthesizer channels through a three-wire serial port. A host shifts a word in on a serial data and serial clock pair, then raises a load enable. The last three bits of each word tell the block what to do with it: which channel receives the word, whether that channel's A/N divider latches or its reference divider latch is written, and whether that channel's open-drain switch output pulls low or releases.

The serial pins come from another clock domain and are resynchronized to the block clock, and their rising edges are detected there. Leading don't-care bits need no special handling. Every field sits at a fixed distance from the trailing control bits, so short words and byte-padded 24-bit words decode the same way. The last stage of the shift register is brought out, so that the programmed stream can be read back or passed on to a cascaded register.

Top module: `serial_prog_if`

## Requirements
- R1: Each rising edge of `sclk_i` shifts `sdata_i` into a 24-bit shift register. `sdo_o` always shows the bit that was shifted in 24 serial clock edges earlier, and shows 0 until 24 bits have been shifted.
- R2: The last bit shifted in steers the word: 1 writes channel index 0 and 0 writes channel index 1. The other channel's latches and switch do not change.
- R3: The second-to-last bit sets the steered channel's `sw_hiz_o` bit (0 means pull low, 1 means high impedance). This happens on every transfer, whichever latch is selected.
- R4: The third-to-last bit selects the latch: 0 writes the N and A latches and 1 writes the reference latch. The latch that is not selected keeps its value.
- R5: An A/N word is 20 bits, shifted MSB first: N (10 bits), then A (7 bits), then the latch select, switch and steer bits. A 24-bit A/N word carries 4 leading bits that are ignored.
- R6: A reference word is 17 bits, shifted MSB first: R (14 bits), then the latch select, switch and steer bits. A 24-bit reference word carries 7 leading bits that are ignored.
- R7: A transfer happens only on a rising edge of `load_en_i`. Shifting while `load_en_i` is low, or while it stays high after its rising edge, changes no latch and no switch.
- R8: After reset, all N, A and reference latches hold 0, both switches are high impedance (1), and `sdo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sdata_i | input | 1 | Serial data, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous; rising edge shifts |
| load_en_i | input | 1 | Load enable; rising edge transfers |
| sdo_o | output | 1 | Last shift register stage |
| n_o | output | 2x10 | N divider latch per channel |
| a_o | output | 2x7 | A divider latch per channel |
| ref_o | output | 2x14 | Reference divider latch per channel |
| sw_hiz_o | output | 2 | Switch state per channel, 1 high impedance, 0 pull low |

## Verification
On every cycle, the assertions check the shift step itself. They also check that a channel's latches stay frozen unless a transfer is steered to it, that the unselected latch of a steered channel keeps its value, and that the switch takes the switch bit on each transfer. The bench scenarios are what show the word formats: the field order of the 17-, 20- and 24-bit words, with junk in the leading bits, decoded into the right N, A and reference values. The scenarios also show the 24-edge delay on the serial output and the effect of holding the enable high while shifting. These need knowledge of the whole serial stream, and a single-cycle property cannot see that.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int unsigned CTRL_W = 3;
  localparam int unsigned NUM_CH = 2;

  typedef enum logic {
    SEL_AN  = 1'b0,
    SEL_REF = 1'b1
  } latch_sel_e;

  typedef struct packed {
    latch_sel_e lsel;
    logic       sw;
    logic       steer;
  } ctrl_t;
endpackage

// File: rtl/slp_sync_edge.sv
module slp_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q[0] <= d_i;
      prev_q     <= chain_q[STAGES-1];
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/slp_shift_reg.sv
module slp_shift_reg #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         din_i,
  output logic [W-1:0] q_o,
  output logic         sdo_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[W-2:0], din_i};
  end

  assign q_o   = sr_q;
  assign sdo_o = sr_q[W-1];

  // R1
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (sr_q[0] == $past(din_i)) && (sr_q[W-1:1] == $past(sr_q[W-2:0])));
  // R1
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sr_q));
endmodule

// File: rtl/slp_chan_latch.sv
module slp_chan_latch
  import slp_pkg::*;
#(
  parameter int unsigned N_W     = 10,
  parameter int unsigned A_W     = 7,
  parameter int unsigned R_W     = 14,
  parameter logic        SEL_VAL = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           xfer_i,
  input  ctrl_t          ctrl_i,
  input  logic [N_W-1:0] n_i,
  input  logic [A_W-1:0] a_i,
  input  logic [R_W-1:0] r_i,
  output logic [N_W-1:0] n_o,
  output logic [A_W-1:0] a_o,
  output logic [R_W-1:0] r_o,
  output logic           sw_hiz_o
);
  logic [N_W-1:0] n_q;
  logic [A_W-1:0] a_q;
  logic [R_W-1:0] r_q;
  logic           sw_q;
  logic           hit;

  assign hit = xfer_i && (ctrl_i.steer == SEL_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q  <= '0;
      a_q  <= '0;
      r_q  <= '0;
      sw_q <= 1'b1;
    end else if (hit) begin
      sw_q <= ctrl_i.sw;
      if (ctrl_i.lsel == SEL_AN) begin
        n_q <= n_i;
        a_q <= a_i;
      end else begin
        r_q <= r_i;
      end
    end
  end

  assign n_o      = n_q;
  assign a_o      = a_q;
  assign r_o      = r_q;
  assign sw_hiz_o = sw_q;

  // R2
  other_chan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && ctrl_i.steer != SEL_VAL) |=> $stable({n_q, a_q, r_q, sw_q}));
  // R7
  no_xfer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable({n_q, a_q, r_q, sw_q}));
  // R3
  sw_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && ctrl_i.steer == SEL_VAL) |=> sw_q == $past(ctrl_i.sw));
  // R4
  ref_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && ctrl_i.steer == SEL_VAL && ctrl_i.lsel == SEL_REF)
      |=> $stable({n_q, a_q}) && r_q == $past(r_i));
  // R4
  an_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && ctrl_i.steer == SEL_VAL && ctrl_i.lsel == SEL_AN)
      |=> $stable(r_q) && n_q == $past(n_i) && a_q == $past(a_i));
endmodule

// File: rtl/serial_prog_if.sv
module serial_prog_if
  import slp_pkg::*;
#(
  parameter int unsigned N_W       = 10,
  parameter int unsigned A_W       = 7,
  parameter int unsigned R_W       = 14,
  parameter int unsigned SR_W      = 24,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sdata_i,
  input  logic                       sclk_i,
  input  logic                       load_en_i,
  output logic                       sdo_o,
  output logic [NUM_CH-1:0][N_W-1:0] n_o,
  output logic [NUM_CH-1:0][A_W-1:0] a_o,
  output logic [NUM_CH-1:0][R_W-1:0] ref_o,
  output logic [NUM_CH-1:0]          sw_hiz_o
);
  localparam int unsigned AN_LEN  = N_W + A_W + CTRL_W;
  localparam int unsigned REF_LEN = R_W + CTRL_W;

  logic            din_s, din_rise;
  logic            sclk_s, sclk_rise;
  logic            en_s, en_rise;
  logic [SR_W-1:0] sr;
  ctrl_t           ctrl;
  logic [N_W-1:0]  n_fld;
  logic [A_W-1:0]  a_fld;
  logic [R_W-1:0]  r_fld;

  slp_sync_edge #(.STAGES(SYNC_STGS)) u_sync_din (
    .clk_i, .rst_ni, .d_i(sdata_i), .level_o(din_s), .rise_o(din_rise));
  slp_sync_edge #(.STAGES(SYNC_STGS)) u_sync_sclk (
    .clk_i, .rst_ni, .d_i(sclk_i), .level_o(sclk_s), .rise_o(sclk_rise));
  slp_sync_edge #(.STAGES(SYNC_STGS)) u_sync_en (
    .clk_i, .rst_ni, .d_i(load_en_i), .level_o(en_s), .rise_o(en_rise));

  slp_shift_reg #(.W(SR_W)) u_sr (
    .clk_i, .rst_ni, .shift_i(sclk_rise), .din_i(din_s), .q_o(sr), .sdo_o(sdo_o));

  // fields are located relative to the trailing control bits
  assign ctrl  = ctrl_t'(sr[CTRL_W-1:0]);
  assign a_fld = sr[CTRL_W +: A_W];
  assign n_fld = sr[CTRL_W + A_W +: N_W];
  assign r_fld = sr[CTRL_W +: R_W];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    slp_chan_latch #(
      .N_W(N_W), .A_W(A_W), .R_W(R_W),
      .SEL_VAL((ch == 0) ? 1'b1 : 1'b0)
    ) u_latch (
      .clk_i, .rst_ni,
      .xfer_i  (en_rise),
      .ctrl_i  (ctrl),
      .n_i     (n_fld),
      .a_i     (a_fld),
      .r_i     (r_fld),
      .n_o     (n_o[ch]),
      .a_o     (a_o[ch]),
      .r_o     (ref_o[ch]),
      .sw_hiz_o(sw_hiz_o[ch])
    );
  end

  initial begin
    // R5
    an_len_fits_chk: assert (AN_LEN <= SR_W);
    // R6
    ref_len_fits_chk: assert (REF_LEN <= SR_W);
  end

  // R7
  single_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rise |=> !en_rise);
  // R2
  one_chan_sw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rise |=> $countones(sw_hiz_o ^ $past(sw_hiz_o)) <= 1);
  // R1
  sdo_tracks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_rise |=> $stable(sdo_o));

  logic unused_levels;
  assign unused_levels = sclk_s ^ en_s ^ din_rise;
endmodule

// File: tb/tb_serial_prog_if.sv
module tb_serial_prog_if;
  localparam int N_W = 10, A_W = 7, R_W = 14, SR_W = 24;

  typedef struct packed {
    logic [1:0][N_W-1:0] n;
    logic [1:0][A_W-1:0] a;
    logic [1:0][R_W-1:0] r;
    logic [1:0]          sw;
  } snap_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0, sclk = 1'b0, load_en = 1'b0;
  logic sdo;
  logic [1:0][N_W-1:0] n_o;
  logic [1:0][A_W-1:0] a_o;
  logic [1:0][R_W-1:0] ref_o;
  logic [1:0]          sw_hiz_o;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit done = 0;

  snap_t exp_q[$];
  string tag_q[$];
  bit    hist[$];
  snap_t model;

  always #2.5 clk = ~clk;

  serial_prog_if dut (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .sclk_i(sclk),
    .load_en_i(load_en), .sdo_o(sdo), .n_o(n_o), .a_o(a_o),
    .ref_o(ref_o), .sw_hiz_o(sw_hiz_o));

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R1: every shift compares sdo against the bench history
  task automatic shift_bit(input bit b);
    sdata = b;
    wait_clk(4);
    sclk = 1'b1;
    hist.push_back(b);
    wait_clk(6);
    check("R1 sdo", 128'(sdo), 128'((hist.size() >= SR_W) ? hist[hist.size()-SR_W] : 1'b0));
    sclk = 1'b0;
    wait_clk(4);
  endtask

  task automatic shift_word(input logic [23:0] w, input int len);
    for (int i = len - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse_en();
    load_en = 1'b1;
    wait_clk(6);
    load_en = 1'b0;
    wait_clk(6);
  endtask

  task automatic push(input string tag);
    exp_q.push_back(model);
    tag_q.push_back(tag);
    wait (exp_q.size() == 0);
    wait_clk(1);
  endtask

  // R5: A/N word {junk, N, A, 0, sw, steer}
  task automatic write_an(input string tag, input bit steer, input bit sw,
                          input logic [N_W-1:0] n, input logic [A_W-1:0] a,
                          input bit wide, input logic [3:0] junk);
    logic [23:0] w;
    int ch;
    w = {junk, n, a, 1'b0, sw, steer};
    shift_word(w, wide ? 24 : 20);
    pulse_en();
    ch = steer ? 0 : 1;
    model.n[ch] = n;
    model.a[ch] = a;
    model.sw[ch] = sw;
    push(tag);
  endtask

  // R6: reference word {junk, R, 1, sw, steer}
  task automatic write_ref(input string tag, input bit steer, input bit sw,
                           input logic [R_W-1:0] r, input bit wide, input logic [6:0] junk);
    logic [23:0] w;
    int ch;
    w = {junk, r, 1'b1, sw, steer};
    shift_word(w, wide ? 24 : 17);
    pulse_en();
    ch = steer ? 0 : 1;
    model.r[ch] = r;
    model.sw[ch] = sw;
    push(tag);
  endtask

  // monitor: pops expected snapshots and compares with the outputs
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        snap_t e;
        snap_t a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a.n = n_o; a.a = a_o; a.r = ref_o; a.sw = sw_hiz_o;
        check({t, " n"},  128'(a.n),  128'(e.n));
        check({t, " a"},  128'(a.a),  128'(e.a));
        check({t, " r"},  128'(a.r),  128'(e.r));
        check({t, " sw"}, 128'(a.sw), 128'(e.sw));
      end
    end
  end

  initial begin
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model = '0;
    model.sw = 2'b11;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
    // R8
    check("R8 sdo", 128'(sdo), 128'(0));
    push("R8 reset");

    write_an("R2 R3 R5 ch0 20b", 1'b1, 1'b0, 10'h2A5, 7'h35, 1'b0, 4'h0);
    write_ref("R4 R6 ch0 17b", 1'b1, 1'b1, 14'h1ABC, 1'b0, 7'h0);
    write_an("R2 R5 ch1 24b junk", 1'b0, 1'b0, 10'h155, 7'h4A, 1'b1, 4'hF);
    write_ref("R3 R6 ch1 24b junk", 1'b0, 1'b0, 14'h2DE1, 1'b1, 7'h7F);
    write_an("R5 ch0 max", 1'b1, 1'b1, 10'h3FF, 7'h7F, 1'b1, 4'hA);
    write_ref("R4 ch1 ref zero", 1'b0, 1'b1, 14'h0000, 1'b0, 7'h0);

    // R7: shift a full word with enable low, no change
    shift_word({4'h0, 10'h0F0, 7'h0F, 1'b0, 1'b0, 1'b1}, 24);
    wait_clk(6);
    push("R7 enable low");
    // R7: enable held high while shifting another word
    load_en = 1'b1;
    wait_clk(6);
    model.n[0] = 10'h0F0; model.a[0] = 7'h0F; model.sw[0] = 1'b0;
    push("R7 rising edge");
    shift_word({4'h0, 10'h111, 7'h22, 1'b0, 1'b1, 1'b0}, 24);
    wait_clk(6);
    push("R7 enable held high");
    load_en = 1'b0;
    wait_clk(6);
    push("R7 enable fall");

    write_an("R3 ch1 sw via AN", 1'b0, 1'b1, 10'h001, 7'h01, 1'b0, 4'h0);

    wait (exp_q.size() == 0);
    wait_clk(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule